// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block takes one request and runs a whole NAND flash operation: erasing a block, programming part of a page, reading part of a page, or reading the device status. A request carries an operation code, a block, page and column address, and a byte count. The block then produces every command, address and data cycle on the flash pins. Program bytes arrive on a valid/ready byte stream. Read bytes leave on a byte output with a one-cycle valid flag.

Before issuing a command the sequencer waits for the device's ready/busy line. It also waits on that line after each confirm command. Every wait is bounded by a cycle limit that the host sets. An erase or program is always followed by a status read, and bit 0 of that status decides the verdict. Each operation ends with a one-cycle completion pulse and a code: 0 is pass, 1 is fail, 2 is timeout. Host software uses a fail on an erase to skip programming that block. Requests whose column range does not fit in a 2,112-byte page are rejected at once and produce no flash activity.

Top module: `nand_op_seq`

## Requirements
- R1: An erase request (op 0) drives, in this order: command 0x60, three address cycles carrying row = block*64 (page bits forced to zero, least significant byte first), command 0xD0, a wait for ready, command 0x70, and one status read.
- R2: A program request (op 1) drives command 0x80, column low byte, column high byte, the three row bytes (row = block*64 + page), then count data bytes taken in stream order from the write input, then 0x10, a wait for ready, 0x70 and one status read.
- R3: A read request (op 2) drives 0x00, the two column bytes, the three row bytes and 0x30. It waits for ready and then delivers count bytes in device order on the read output, each with a single-cycle valid.
- R4: A status request (op 3) drives only command 0x70 and one status read. It reports pass and presents the status byte on the status output during the completion pulse.
- R5: No command or address cycle starts while ready/busy reads busy. The sequencer waits for ready before the first command of every request.
- R6: After an erase or program, status bit 0 equal to 1 gives result 1 (fail). Otherwise the result is 0 (pass).
- R7: If any wait on ready/busy lasts past the programmed cycle limit, the result is 2 (timeout) and no further flash cycle is driven for that request.
- R8: A program or read request with a count of zero, a start column above 2111, or column plus count above 2112 completes on the next cycle with result 1. Chip enable stays high and no flash cycle is driven.
- R9: Chip enable is low only while an accepted request is in progress. Write protect is high only during erase and program requests.
- R10: Command cycles have CLE=1 and ALE=0. Address cycles have ALE=1 and CLE=0. The bus is valid at every rising edge of write enable. Write enable and read enable are never low together, and the bus is not driven while read enable is low.
- R11: The request is accepted only while ready is high. The completion pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 2 | 0 erase, 1 program, 2 read, 3 status |
| req_block | input | 11 | Block number |
| req_page | input | 6 | Page within block |
| req_col | input | 12 | Start column |
| req_count | input | 12 | Byte count |
| tmo_limit | input | 16 | Cycle limit for each ready/busy wait |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte valid |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout |
| stat_byte | output | 8 | Last status byte read |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write enable, active low |
| fl_re_n | output | 1 | Read enable, active low |
| fl_wp_n | output | 1 | Write protect, active low |
| fl_io_out | output | 8 | Bus value driven to the device |
| fl_io_oe | output | 1 | Bus drive enable |
| fl_io_in | input | 8 | Bus value from the device |
| fl_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with its default geometry: 2,048 blocks, 64 pages and 2,112-byte pages, with a 16-bit timeout counter. Columns near 2,111 therefore make both the exact page-end fit and the one-past-the-end reject reachable. The timeout limit is a run-time input. The bench sets it to 5,000 for normal traffic and to 40 against a device held busy for 3,000 cycles, so timeouts before the first command and after a confirm are both reached in a few hundred cycles.

// File: rtl/nand_seq_pkg.sv
// Shared encodings for the NAND page operation sequencer.
// Assumes an 8-bit multiplexed device bus and the usual two-phase command set.
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE  = 2'd0,
        OP_PROG   = 2'd1,
        OP_READ   = 2'd2,
        OP_STATUS = 2'd3
    } nand_op_e;

    typedef enum logic [1:0] {
        RES_PASS = 2'd0,
        RES_FAIL = 2'd1,
        RES_TMO  = 2'd2
    } nand_res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WRDY, S_CMD1, S_ADDR, S_LOAD, S_DIN, S_CMD2,
        S_TWB, S_BUSY, S_DOUT, S_SCMD, S_SRD, S_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
    localparam logic [7:0] CMD_READ_GO     = 8'h30;
    localparam logic [7:0] CMD_STAT        = 8'h70;

endpackage

// File: rtl/nand_req_check.sv
// Request range check: decides whether a program or read request fits in one page.
// Assumes erase and status requests need no column check.
module nand_req_check
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int COL_W      = 12,
    parameter int CNT_W      = 12
) (
    input  logic [1:0]       op,
    input  logic [COL_W-1:0] col,
    input  logic [CNT_W-1:0] count,
    output logic             ok
);
    localparam int SUM_W = ((COL_W > CNT_W) ? COL_W : CNT_W) + 1;

    logic [SUM_W-1:0] span_end;

    // Combinational fit test on the requested column window.
    always_comb begin
        span_end = SUM_W'(col) + SUM_W'(count);
        if (op == OP_PROG || op == OP_READ)
            ok = (count != '0) && (SUM_W'(col) < SUM_W'(PAGE_BYTES))
                 && (span_end <= SUM_W'(PAGE_BYTES));
        else
            ok = 1'b1;
    end
endmodule

// File: rtl/nand_busy_timer.sv
// Bounded wait on ready/busy: reports ready, or expiry after limit busy cycles.
// Assumes run drops between separate waits so each wait starts from zero.
module nand_busy_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rb_n,
    input  logic [TMO_W-1:0] limit,
    output logic             ready,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Count busy cycles while a wait is active, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || rb_n)   cnt <= '0;
        else if (cnt != limit)   cnt <= cnt + 1'b1;
    end

    assign ready   = run && rb_n;
    assign expired = run && !rb_n && (cnt == limit);
endmodule

// File: rtl/nand_op_seq.sv
// NAND page operation sequencer: runs erase, program, read and status
// transactions from one request and reports pass, fail or timeout.
// Assumes one clock per strobe phase meets the device's setup and hold
// times, and that fl_rb_n is already synchronous to clk.
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int BLOCKS     = 2048,
    parameter int PAGES      = 64,
    parameter int PAGE_BYTES = 2112,
    parameter int TMO_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_op,
    input  logic [$clog2(BLOCKS)-1:0]     req_block,
    input  logic [$clog2(PAGES)-1:0]      req_page,
    input  logic [$clog2(PAGE_BYTES)-1:0] req_col,
    input  logic [$clog2(PAGE_BYTES+1)-1:0] req_count,
    input  logic [TMO_W-1:0]              tmo_limit,
    input  logic [7:0]                    wr_data,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    output logic [7:0]                    rd_data,
    output logic                          rd_valid,
    output logic                          done,
    output logic [1:0]                    result,
    output logic [7:0]                    stat_byte,
    output logic                          fl_ce_n,
    output logic                          fl_cle,
    output logic                          fl_ale,
    output logic                          fl_we_n,
    output logic                          fl_re_n,
    output logic                          fl_wp_n,
    output logic [7:0]                    fl_io_out,
    output logic                          fl_io_oe,
    input  logic [7:0]                    fl_io_in,
    input  logic                          fl_rb_n
);
    localparam int BLK_W = $clog2(BLOCKS);
    localparam int PG_W  = $clog2(PAGES);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PAGE_BYTES+1);

    seq_state_e        state;
    nand_op_e          op_q;
    nand_res_e         res_q;
    logic              phase_q;
    logic [39:0]       addr_q;
    logic [2:0]        idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        dreg_q, stat_q, rd_data_q;
    logic              rd_valid_q;
    logic              req_ok, wait_run, rdy_hit, tmo_hit;
    logic [PG_W-1:0]   page_eff;
    logic              strobe_w, strobe_r;

    nand_req_check #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .CNT_W(CNT_W)) u_check (
        .op(req_op), .col(req_col), .count(req_count), .ok(req_ok)
    );

    assign wait_run = (state == S_WRDY) || (state == S_BUSY);

    nand_busy_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .rb_n(fl_rb_n),
        .limit(tmo_limit), .ready(rdy_hit), .expired(tmo_hit)
    );

    assign page_eff = (nand_op_e'(req_op) == OP_ERASE) ? '0 : req_page;

    // Sequence control: walks command, address, data and wait steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_STATUS;
            res_q      <= RES_PASS;
            phase_q    <= 1'b0;
            addr_q     <= '0;
            idx_q      <= '0;
            cnt_q      <= '0;
            dreg_q     <= '0;
            stat_q     <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= nand_op_e'(req_op);
                    addr_q <= {24'({req_block, page_eff}), 16'(req_col)};
                    cnt_q  <= req_count;
                    res_q  <= req_ok ? RES_PASS : RES_FAIL;
                    state  <= req_ok ? S_WRDY : S_DONE;
                end
                S_WRDY: begin
                    idx_q <= (op_q == OP_ERASE) ? 3'd2 : 3'd0;
                    if (tmo_hit) begin
                        res_q <= RES_TMO;
                        state <= S_DONE;
                    end else if (rdy_hit)
                        state <= (op_q == OP_STATUS) ? S_SCMD : S_CMD1;
                end
                S_CMD1: begin
                    phase_q <= ~phase_q;
                    if (phase_q) state <= S_ADDR;
                end
                S_ADDR: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        if (idx_q == 3'd4) state <= (op_q == OP_PROG) ? S_LOAD : S_CMD2;
                        else               idx_q <= idx_q + 3'd1;
                    end
                end
                S_LOAD: if (wr_valid) begin
                    dreg_q <= wr_data;
                    state  <= S_DIN;
                end
                S_DIN: begin
                    phase_q <= ~phase_q;
                    if (phase_q) begin
                        if (cnt_q == CNT_W'(1)) state <= S_CMD2;
                        else begin
                            cnt_q <= cnt_q - 1'b1;
                            state <= S_LOAD;
                        end
                    end
                end
                S_CMD2: begin
                    phase_q <= ~phase_q;
                    if (phase_q) state <= S_TWB;
                end
                S_TWB: state <= S_BUSY;
                S_BUSY: begin
                    if (tmo_hit) begin
                        res_q <= RES_TMO;
                        state <= S_DONE;
                    end else if (rdy_hit)
                        state <= (op_q == OP_READ) ? S_DOUT : S_SCMD;
                end
                S_DOUT: begin
                    phase_q <= ~phase_q;
                    if (!phase_q) begin
                        rd_data_q  <= fl_io_in;
                        rd_valid_q <= 1'b1;
                    end else if (cnt_q == CNT_W'(1)) begin
                        res_q <= RES_PASS;
                        state <= S_DONE;
                    end else
                        cnt_q <= cnt_q - 1'b1;
                end
                S_SCMD: begin
                    phase_q <= ~phase_q;
                    if (phase_q) state <= S_SRD;
                end
                S_SRD: begin
                    phase_q <= ~phase_q;
                    if (!phase_q) stat_q <= fl_io_in;
                    else begin
                        res_q <= (op_q != OP_STATUS && stat_q[0]) ? RES_FAIL : RES_PASS;
                        state <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign strobe_w = (state == S_CMD1) || (state == S_ADDR) || (state == S_DIN)
                   || (state == S_CMD2) || (state == S_SCMD);
    assign strobe_r = (state == S_DOUT) || (state == S_SRD);

    // Bus value selection for the current write cycle.
    always_comb begin
        case (state)
            S_CMD1:  fl_io_out = (op_q == OP_ERASE) ? CMD_ERASE_SETUP :
                                 (op_q == OP_PROG)  ? CMD_PROG_SETUP  : CMD_READ_SETUP;
            S_ADDR:  fl_io_out = addr_q[{idx_q, 3'b000} +: 8];
            S_DIN:   fl_io_out = dreg_q;
            S_CMD2:  fl_io_out = (op_q == OP_ERASE) ? CMD_ERASE_GO :
                                 (op_q == OP_PROG)  ? CMD_PROG_GO  : CMD_READ_GO;
            S_SCMD:  fl_io_out = CMD_STAT;
            default: fl_io_out = 8'h00;
        endcase
    end

    assign fl_io_oe  = strobe_w;
    assign fl_cle    = (state == S_CMD1) || (state == S_CMD2) || (state == S_SCMD);
    assign fl_ale    = (state == S_ADDR);
    assign fl_we_n   = !(strobe_w && !phase_q);
    assign fl_re_n   = !(strobe_r && !phase_q);
    assign fl_ce_n   = (state == S_IDLE) || (state == S_DONE);
    assign fl_wp_n   = !fl_ce_n && (op_q == OP_ERASE || op_q == OP_PROG);
    assign req_ready = (state == S_IDLE);
    assign wr_ready  = (state == S_LOAD);
    assign rd_data   = rd_data_q;
    assign rd_valid  = rd_valid_q;
    assign done      = (state == S_DONE);
    assign result    = res_q;
    assign stat_byte = stat_q;

    AST_REJECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_ok) |=> (done && result == RES_FAIL)); // R8
    AST_TMO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (done && result == RES_TMO)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n)); // R10
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R10
    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> !fl_io_oe); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_ce_n); // R9
endmodule

// File: tb/tb_nand_op_seq.sv
// Bench for the NAND page operation sequencer: a behavioural device model,
// directed corner cases and seeded random requests.
module tb_nand_op_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_ready, wr_valid, wr_ready, rd_valid, done;
    logic [1:0]  req_op, result;
    logic [10:0] req_block;
    logic [5:0]  req_page;
    logic [11:0] req_col, req_count;
    logic [15:0] tmo_limit;
    logic [7:0]  wr_data, rd_data, stat_byte, fl_io_out, fl_io_in;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_wp_n, fl_io_oe, fl_rb_n;

    nand_op_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_block(req_block), .req_page(req_page), .req_col(req_col),
        .req_count(req_count), .tmo_limit(tmo_limit), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .result(result), .stat_byte(stat_byte), .fl_ce_n(fl_ce_n),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
        .fl_wp_n(fl_wp_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in), .fl_rb_n(fl_rb_n)
    );

    int checks = 0, fails = 0;

    function automatic logic [7:0] dev_byte(input int k);
        return 8'(k * 29 + 11);
    endfunction
    function automatic logic [7:0] src_byte(input int k);
        return 8'(k * 53) ^ 8'hA5;
    endfunction

    // Device model: ready/busy line
    int busy_left = 0, busy_len = 1, pre_len = 0;
    int confirm_cnt = 0, confirm_ack = 0, pre_req = 0, pre_ack = 0;
    assign fl_rb_n = (busy_left == 0);
    always @(negedge clk) begin
        if (confirm_cnt != confirm_ack) begin
            busy_left = busy_len; confirm_ack = confirm_cnt;
        end else if (pre_req != pre_ack) begin
            busy_left = pre_len; pre_ack = pre_req;
        end else if (busy_left > 0) busy_left = busy_left - 1;
    end

    // Device model: write-cycle log and read data
    logic [9:0] log_q [0:8191];
    int log_n = 0, viol_busy = 0, rdk = 0;
    logic stat_mode = 1'b0;
    logic [7:0] stat_val = 8'h00;
    always @(posedge fl_we_n) if (rst_n) begin
        if (!fl_rb_n) viol_busy = viol_busy + 1;
        log_q[log_n[12:0]] = {fl_cle, fl_ale, fl_io_out};
        log_n = log_n + 1;
        if (fl_cle) begin
            stat_mode = (fl_io_out == 8'h70);
            rdk = 0;
            if (fl_io_out == 8'hD0 || fl_io_out == 8'h10 || fl_io_out == 8'h30)
                confirm_cnt = confirm_cnt + 1;
        end
    end
    always @(negedge fl_re_n) if (rst_n) begin
        fl_io_in = stat_mode ? stat_val : dev_byte(rdk);
        rdk = rdk + 1;
    end

    // Program data source and read collector
    int feed_idx = 0, rd_n = 0;
    logic [7:0] rd_q [0:8191];
    assign wr_data = src_byte(feed_idx);
    always @(posedge clk) begin
        if (wr_valid && wr_ready) feed_idx <= feed_idx + 1;
        if (rd_valid) begin
            rd_q[rd_n[12:0]] <= rd_data;
            rd_n <= rd_n + 1;
        end
    end

    // Pin monitors
    int ce_low = 0, wp_high = 0, strobe_bad = 0;
    always @(posedge clk) if (rst_n) begin
        if (!fl_ce_n) ce_low = ce_low + 1;
        if (fl_wp_n) wp_high = wp_high + 1;
        if ((!fl_we_n && !fl_re_n) || (fl_cle && fl_ale)) strobe_bad = strobe_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic bit fits(input int op, input int col, input int cnt);
        if (op == 1 || op == 2) return (cnt > 0) && (col <= 2111) && (col + cnt <= 2112);
        return 1'b1;
    endfunction

    // mode: 0 normal, 1 busy before request (times out), 2 long busy after confirm, 3 short busy before
    task automatic do_op(input int op, input int blk, input int pg, input int col, input int cnt,
                         input logic [7:0] st, input int blen, input int mode, input string tag);
        logic [9:0] exp_q [0:2399];
        int ne = 0, lb, rb, fb, ceb, wpb, row, eres, wait_n;
        logic [1:0] res;
        logic [7:0] sb;
        logic done_next;
        bit ok;
        stat_val  = st;
        busy_len  = blen;
        tmo_limit = (mode == 1 || mode == 2) ? 16'd40 : 16'd5000;
        wr_valid  = 1'b1;
        lb = log_n; rb = rd_n; fb = feed_idx; ceb = ce_low; wpb = wp_high;
        if (mode == 1 || mode == 3) begin
            pre_len = (mode == 1) ? 3000 : 30; pre_req++;
            @(negedge clk);
        end
        while (!req_ready) @(negedge clk);
        req_op = 2'(op); req_block = 11'(blk); req_page = 6'(pg);
        req_col = 12'(col); req_count = 12'(cnt); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 30000) begin @(negedge clk); wait_n++; end
        res = result; sb = stat_byte;
        @(negedge clk);
        done_next = done;
        chk(!done_next, "R11", {tag, " done width"}, int'(done_next), 0);
        pre_len = 0; pre_req++;
        row = blk * 64 + ((op == 0) ? 0 : pg);
        if (!fits(op, col, cnt)) eres = 1;
        else if (mode == 1 || mode == 2) eres = 2;
        else if (op == 3) eres = 0;
        else if (op == 2) eres = 0;
        else eres = st[0] ? 1 : 0;
        if (fits(op, col, cnt) && mode != 1) begin
            if (op != 3) begin
                exp_q[ne++] = {2'b10, (op == 0) ? 8'h60 : (op == 1) ? 8'h80 : 8'h00};
                if (op != 0) begin
                    exp_q[ne++] = {2'b01, 8'(col)};
                    exp_q[ne++] = {2'b01, 8'(col >> 8)};
                end
                exp_q[ne++] = {2'b01, 8'(row)};
                exp_q[ne++] = {2'b01, 8'(row >> 8)};
                exp_q[ne++] = {2'b01, 8'(row >> 16)};
                if (op == 1) for (int k = 0; k < cnt; k++) exp_q[ne++] = {2'b00, src_byte(fb + k)};
                exp_q[ne++] = {2'b10, (op == 0) ? 8'hD0 : (op == 1) ? 8'h10 : 8'h30};
            end
            if (mode != 2 && op != 2) exp_q[ne++] = {2'b10, 8'h70};
        end
        ok = (log_n - lb == ne);
        for (int k = 0; k < ne && ok; k++) ok = (log_q[(lb + k) % 8192] == exp_q[k]);
        chk(ok, (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R4",
            {tag, " write-cycle sequence (count)"}, log_n - lb, ne);
        chk(int'(res) == eres, (mode == 1 || mode == 2) ? "R7" : (!fits(op, col, cnt)) ? "R8" : "R6",
            {tag, " result"}, int'(res), eres);
        if (op == 2 && eres == 0) begin
            ok = (rd_n - rb == cnt);
            for (int k = 0; k < cnt && ok; k++) ok = (rd_q[(rb + k) % 8192] == dev_byte(k));
            chk(ok, "R3", {tag, " read bytes (count)"}, rd_n - rb, cnt);
        end
        if (op == 3 && eres == 0) chk(sb == st, "R4", {tag, " status byte"}, int'(sb), int'(st));
        if (!fits(op, col, cnt)) chk(ce_low == ceb, "R8", {tag, " chip enable cycles"}, ce_low - ceb, 0);
        if (op == 2 || op == 3) chk(wp_high == wpb, "R9", {tag, " write protect released"}, wp_high - wpb, 0);
        else if (fits(op, col, cnt)) chk(wp_high > wpb, "R9", {tag, " write protect released"}, wp_high - wpb, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; wr_valid = 1'b0; fl_io_in = 8'h00;
        req_op = '0; req_block = '0; req_page = '0; req_col = '0; req_count = '0;
        tmo_limit = 16'd5000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_re_n && !fl_wp_n, "R9", "reset pins", int'({fl_ce_n, fl_we_n, fl_re_n, fl_wp_n}), 14);
        chk(req_ready && !done, "R11", "reset ready", int'({req_ready, done}), 2);

        do_op(0, 1234, 17, 0, 0, 8'hE0, 12, 0, "erase pass");
        do_op(0, 2047, 0, 0, 0, 8'hE1, 5, 0, "erase fail");
        do_op(1, 3, 9, 0, 5, 8'hE0, 8, 0, "program start");
        do_op(1, 77, 63, 2107, 5, 8'hC1, 4, 0, "program fail at page end");
        do_op(2, 500, 33, 2100, 12, 8'h00, 10, 0, "read to page end");
        do_op(2, 1, 1, 2112, 1, 8'h00, 3, 0, "read column over");
        do_op(1, 1, 1, 2111, 2, 8'h00, 3, 0, "program runs past end");
        do_op(2, 1, 1, 10, 0, 8'h00, 3, 0, "read zero count");
        do_op(3, 0, 0, 0, 0, 8'h5B, 3, 0, "status");
        do_op(3, 0, 0, 0, 0, 8'hC0, 3, 3, "status after busy");
        do_op(3, 0, 0, 0, 0, 8'hC0, 3, 1, "timeout before command");
        do_op(0, 99, 0, 0, 0, 8'hE0, 3000, 2, "timeout after confirm");

        void'($urandom(32'd1337));
        for (int i = 0; i < 24; i++) begin
            int op, cnt, col;
            op  = int'($urandom % 4);
            cnt = 1 + int'($urandom % 16);
            col = int'($urandom % (2113 - cnt));
            if ($urandom % 5 == 0) col = 2100 + int'($urandom % 20);
            do_op(op, int'($urandom % 2048), int'($urandom % 64), col, cnt,
                  8'($urandom), 1 + int'($urandom % 20), 0, "random");
        end

        chk(viol_busy == 0, "R5", "cycles started while busy", viol_busy, 0);
        chk(strobe_bad == 0, "R10", "strobe overlap cycles", strobe_bad, 0);
        summary();
        $finish;
    end
endmodule